// File: doc/BRIEF.md
# Multi-Channel Overcurrent Fault Controller

This block is the digital control core of an eight-channel high-side output driver. Each channel's gate-drive enable follows its active-high logic input, but only while the shared enable/reset line is high, the die is not in thermal shutdown, and that channel has not been shut down by its own overcurrent latch. The analog sense comparators and the temperature monitor appear only as digital flags.

When a channel turns on, its comparator flag is ignored for a blanking window of `BLANK_CYC` clock cycles so that the inrush or crossover current of an inductive load does not trip it. A flag still present when the window has run out sets that channel's latch. The channel then stays off, while all other channels keep working, until the latch is cleared by the enable/reset line going low, by a thermal shutdown, or by power-on reset. Thermal shutdown uses two flags for hysteresis: a trip flag enters shutdown, and a separate release flag leaves it. A common active-low fault output reports any set latch or an active shutdown. All flag and logic inputs cross into the clock domain through two-flop synchronizers.

Top module: `ovc_fault_ctrl`

## Requirements
- R1: With enable/reset high, no thermal shutdown and no latch set, `gateOut[i]` equals `chanIn[i]` delayed by exactly three rising clock edges (two synchronizer stages plus the output register).
- R2: A set overcurrent latch forces only its own channel off; every other channel keeps following its input.
- R3: While `ocFlag[i]` stays high, a channel that turns on stays on for exactly `BLANK_CYC`+1 clock cycles and then latches off.
- R4: A comparator pulse that arrives and leaves within the blanking window has no effect: the channel stays on and the fault output stays high.
- R5: The blanking count restarts every time the channel's output goes from off to on, so a re-enabled channel again gets the full window.
- R6: Enable/reset low forces all outputs off and clears all latches; when it goes high again, channels with a clear comparator flag follow their inputs.
- R7: Power-on reset (`porN` low) clears all latches and forces all outputs off, whatever the level of enable/reset.
- R8: `thermHot` high enters thermal shutdown: all outputs go off and all latches clear. The shutdown persists after `thermHot` falls and ends only when `thermCool` is high. If both flags are high, `thermHot` wins.
- R9: `faultN` is low exactly while any channel latch is set or thermal shutdown is active, and high otherwise (including directly after reset).
- R10: Dropping a latched channel's own input does not clear its latch: the fault stays low and the channel stays off when the input returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| chanIn | input | N_CH | Per-channel logic inputs, active high, asynchronous |
| ocFlag | input | N_CH | Per-channel overcurrent comparator flags, asynchronous |
| enRst | input | 1 | Shared output enable; low disables all outputs and clears latches |
| thermHot | input | 1 | Temperature above trip threshold, asynchronous |
| thermCool | input | 1 | Temperature below release threshold, asynchronous |
| gateOut | output | N_CH | Per-channel gate-drive enables |
| faultN | output | 1 | Common fault indication, active low |

## Verification
The bench measures the on-time of a channel under a standing comparator flag. A design with an off-by-one blanking counter gives a pulse one cycle too long or too short, and one that keeps the count across an off period trips a re-enabled channel early. Short comparator pulses inside the window catch a design that samples the flag before blanking ends. A latched channel is also driven with its input dropped and restored, with its neighbours toggled, and with a thermal trip released only by the trip flag. These expose a latch tied to the input, shutdowns that leak between channels, and a thermal state without hysteresis.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  // Strobes from the control module to the per-channel datapath.
  typedef struct packed {
    logic killAll;     // force every gate off this cycle
    logic clearLatch;  // clear every overcurrent latch this cycle
  } ovcStrobe_t;
endpackage

// File: rtl/ovc_sync.sv
module ovc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/ovc_control.sv
module ovc_control #(
  parameter int N_CH = 8
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   enS,
  input  logic                   hotS,
  input  logic                   coolS,
  input  logic [N_CH-1:0]        latchVec,
  output ovc_pkg::ovcStrobe_t    strobe,
  output logic                   thermOn,
  output logic                   faultN
);
  // Thermal state with hysteresis: trip flag sets, release flag clears.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      thermOn <= 1'b0;
    end else if (hotS) begin
      thermOn <= 1'b1;
    end else if (coolS) begin
      thermOn <= 1'b0;
    end
  end

  always_comb begin
    strobe.killAll    = !enS || thermOn;
    strobe.clearLatch = !enS || thermOn;
  end

  assign faultN = !((|latchVec) || thermOn);
endmodule

// File: rtl/ovc_datapath.sv
module ovc_datapath #(
  parameter int N_CH      = 8,
  parameter int BLANK_CYC = 200
) (
  input  logic                clk,
  input  logic                porN,
  input  logic [N_CH-1:0]     inS,
  input  logic [N_CH-1:0]     ocS,
  input  ovc_pkg::ovcStrobe_t strobe,
  output logic [N_CH-1:0]     gateOut,
  output logic [N_CH-1:0]     latchVec
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [CW-1:0] blankCnt;
    logic          blankDone;
    logic          tripNow;

    assign blankDone = (blankCnt == BLANK_END);
    assign tripNow   = gateOut[ch] && blankDone && ocS[ch];

    // Blanking counter: zero while off, counts on-cycles, saturates.
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        blankCnt <= '0;
      end else if (!gateOut[ch]) begin
        blankCnt <= '0;
      end else if (!blankDone) begin
        blankCnt <= blankCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        latchVec[ch] <= 1'b0;
      end else if (strobe.clearLatch) begin
        latchVec[ch] <= 1'b0;
      end else if (tripNow) begin
        latchVec[ch] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        gateOut[ch] <= 1'b0;
      end else begin
        gateOut[ch] <= inS[ch] && !strobe.killAll && !latchVec[ch] && !tripNow;
      end
    end
  end
endmodule

// File: rtl/ovc_fault_ctrl.sv
module ovc_fault_ctrl #(
  parameter int N_CH      = 8,
  parameter int BLANK_CYC = 200
) (
  input  logic            clk,
  input  logic            porN,
  input  logic [N_CH-1:0] chanIn,
  input  logic [N_CH-1:0] ocFlag,
  input  logic            enRst,
  input  logic            thermHot,
  input  logic            thermCool,
  output logic [N_CH-1:0] gateOut,
  output logic            faultN
);
  localparam int SW = 2 * N_CH + 3;

  logic [SW-1:0]        syncVec;
  logic [N_CH-1:0]      inS;
  logic [N_CH-1:0]      ocS;
  logic                 enS;
  logic                 hotS;
  logic                 coolS;
  logic [N_CH-1:0]      latchVec;
  logic                 thermOn;
  ovc_pkg::ovcStrobe_t  strobe;

  ovc_sync #(.WIDTH(SW)) u_sync (
    .clk     (clk),
    .porN    (porN),
    .asyncIn ({thermCool, thermHot, enRst, ocFlag, chanIn}),
    .syncOut (syncVec)
  );

  assign {coolS, hotS, enS, ocS, inS} = syncVec;

  ovc_control #(.N_CH(N_CH)) u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .enS      (enS),
    .hotS     (hotS),
    .coolS    (coolS),
    .latchVec (latchVec),
    .strobe   (strobe),
    .thermOn  (thermOn),
    .faultN   (faultN)
  );

  ovc_datapath #(.N_CH(N_CH), .BLANK_CYC(BLANK_CYC)) u_dp (
    .clk      (clk),
    .porN     (porN),
    .inS      (inS),
    .ocS      (ocS),
    .strobe   (strobe),
    .gateOut  (gateOut),
    .latchVec (latchVec)
  );
endmodule

// File: rtl/ovc_fault_ctrl_chk.sv
module ovc_fault_ctrl_chk #(
  parameter int N_CH = 8
) (
  input logic                clk,
  input logic                porN,
  input logic [N_CH-1:0]     gateOut,
  input logic                faultN,
  input logic [N_CH-1:0]     latchVec,
  input logic                thermOn,
  input ovc_pkg::ovcStrobe_t strobe
);
  // R6/R8: a kill strobe turns every gate off on the next edge.
  a_r6_kill_gates_off: assert property (@(posedge clk) disable iff (!porN)
    strobe.killAll |=> (gateOut == '0));

  // R6/R8: a clear strobe empties every latch on the next edge.
  a_r6_clear_latches: assert property (@(posedge clk) disable iff (!porN)
    strobe.clearLatch |=> (latchVec == '0));

  // R2: a latched channel never drives its gate.
  a_r2_latched_is_off: assert property (@(posedge clk) disable iff (!porN)
    ((latchVec & gateOut) == '0));

  // R10: without a clear strobe, no latch ever falls.
  a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!porN)
    !strobe.clearLatch |=> ((latchVec & $past(latchVec)) == $past(latchVec)));

  // R9: a newly set latch shows on the fault output.
  a_r9_latch_faults: assert property (@(posedge clk) disable iff (!porN)
    $rose(|latchVec) |-> !faultN);

  // R8: active thermal shutdown holds every gate off.
  a_r8_therm_off: assert property (@(posedge clk) disable iff (!porN)
    thermOn && $past(thermOn) |-> (gateOut == '0));
endmodule

bind ovc_fault_ctrl ovc_fault_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk      (clk),
  .porN     (porN),
  .gateOut  (gateOut),
  .faultN   (faultN),
  .latchVec (latchVec),
  .thermOn  (thermOn),
  .strobe   (strobe)
);

// File: tb/ovc_fault_ctrl_test.sv
`timescale 1ns/1ps
module ovc_fault_ctrl_test;
  localparam int N_CH  = 8;
  localparam int BLANK = 16;

  logic            clk = 1'b0;
  logic            porN = 1'b0;
  logic [N_CH-1:0] chanIn = '0;
  logic [N_CH-1:0] ocFlag = '0;
  logic            enRst = 1'b0;
  logic            thermHot = 1'b0;
  logic            thermCool = 1'b0;
  logic [N_CH-1:0] gateOut;
  logic            faultN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ovc_fault_ctrl #(.N_CH(N_CH), .BLANK_CYC(BLANK)) uut (
    .clk(clk), .porN(porN), .chanIn(chanIn), .ocFlag(ocFlag), .enRst(enRst),
    .thermHot(thermHot), .thermCool(thermCool), .gateOut(gateOut), .faultN(faultN)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkGates(input string req, input logic [N_CH-1:0] exp);
    check(gateOut === exp, req, int'(gateOut), int'(exp));
  endtask

  task automatic checkFault(input string req, input logic exp);
    check(faultN === exp, req, int'(faultN), int'(exp));
  endtask

  // Counts consecutive negedges with gateOut[ch] high (starting high).
  task automatic measureOn(input int ch, output int len);
    len = 0;
    while (gateOut[ch] === 1'b1 && len < 1000) begin
      len++;
      tick(1);
    end
  endtask

  // Clear all latches via enable/reset and return to idle.
  task automatic cleanSlate();
    chanIn = '0; ocFlag = '0; thermHot = 0; thermCool = 0;
    enRst = 0; tick(5); enRst = 1; tick(5);
  endtask

  task automatic testReset();
    checkGates("R7 reset gates", '0);
    checkFault("R9 reset fault", 1'b1);
  endtask

  task automatic testFollow();
    chanIn = 8'hA5; tick(2);
    checkGates("R1 not before 3 edges", '0);
    tick(1);
    checkGates("R1 three-edge latency", 8'hA5);
    chanIn = 8'h3C; tick(5);
    checkGates("R1 follow pattern", 8'h3C);
    checkFault("R9 idle fault high", 1'b1);
    chanIn = '0; tick(5);
  endtask

  task automatic testBlankTrip();
    int len;
    ocFlag[2] = 1; chanIn[2] = 1;
    while (gateOut[2] !== 1'b1) tick(1);
    measureOn(2, len);
    check(len == BLANK + 1, "R3 on-time under standing flag", len, BLANK + 1);
    tick(2);
    checkFault("R9 latch fault low", 1'b0);
    cleanSlate();
  endtask

  task automatic testBlankIgnore();
    chanIn[4] = 1; tick(4);
    ocFlag[4] = 1; tick(6); ocFlag[4] = 0;
    tick(BLANK + 10);
    checkGates("R4 short pulse ignored", 8'h10);
    checkFault("R4 fault stays high", 1'b1);
    cleanSlate();
  endtask

  task automatic testIsolation();
    chanIn = 8'hFF; tick(5);
    ocFlag[1] = 1; tick(BLANK + 8); ocFlag[1] = 0;
    checkGates("R2 only channel 1 off", 8'hFD);
    chanIn = 8'h0F; tick(5);
    checkGates("R2 others still follow", 8'h0D);
    cleanSlate();
  endtask

  task automatic testRetrigger();
    int len;
    ocFlag[3] = 1; chanIn[3] = 1; tick(BLANK / 2); chanIn[3] = 0; tick(6);
    checkGates("R5 first run did not trip", '0);
    checkFault("R5 no fault after short run", 1'b1);
    chanIn[3] = 1;
    while (gateOut[3] !== 1'b1) tick(1);
    measureOn(3, len);
    check(len == BLANK + 1, "R5 full window after restart", len, BLANK + 1);
    cleanSlate();
  endtask

  task automatic testInputDrop();
    chanIn[5] = 1; ocFlag[5] = 1; tick(BLANK + 8); ocFlag[5] = 0;
    chanIn[5] = 0; tick(5); chanIn[5] = 1; tick(6);
    checkGates("R10 latched stays off", '0);
    checkFault("R10 fault persists", 1'b0);
    enRst = 0; tick(4);
    checkGates("R6 enable low forces off", '0);
    enRst = 1; tick(6);
    checkGates("R6 latch cleared by enable", 8'h20);
    checkFault("R6 fault released", 1'b1);
    chanIn = '0; tick(5);
  endtask

  task automatic testThermal();
    chanIn = 8'hC3; ocFlag[0] = 1; tick(BLANK + 8); ocFlag[0] = 0;
    checkGates("R2 channel 0 latched", 8'hC2);
    thermHot = 1; tick(5);
    checkGates("R8 thermal kills all", '0);
    checkFault("R9 thermal fault", 1'b0);
    thermHot = 0; tick(6);
    checkGates("R8 hysteresis holds off", '0);
    thermCool = 1; thermHot = 1; tick(6);
    checkGates("R8 hot wins over cool", '0);
    thermHot = 0; tick(6); thermCool = 0; tick(2);
    checkGates("R8 release, latch cleared", 8'hC3);
    checkFault("R9 fault clears after release", 1'b1);
    cleanSlate();
  endtask

  task automatic testPor();
    chanIn[6] = 1; ocFlag[6] = 1; tick(BLANK + 8); ocFlag[6] = 0;
    checkFault("R7 latch before por", 1'b0);
    porN = 0; tick(2);
    checkGates("R7 por forces off", '0);
    porN = 1; tick(6);
    checkGates("R7 por cleared latch", 8'h40);
    checkFault("R7 fault high after por", 1'b1);
    cleanSlate();
  endtask

  initial begin
    tick(3);
    testReset();
    porN = 1; tick(2);
    testReset();
    enRst = 1; tick(4);
    testFollow();
    testBlankTrip();
    testBlankIgnore();
    testIsolation();
    testRetrigger();
    testInputDrop();
    testThermal();
    testPor();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule